// File: doc/BRIEF.md
# Audio sample FIFO write packer

This block is the transmit-side storage of an audio serial port, together with its write front end. Software writes samples over a 32-bit bus that has four byte enables. A sample may arrive in one full-width write or in several narrow writes, ordered from the low byte to the high byte. The block keeps the low bytes of a partial sample in a staging register. It pushes the finished sample into a FIFO when the write carrying the top byte of the selected sample length arrives.

A 2-bit mode input sets the sample length. It also sets the FIFO geometry. The storage is shared between the modes: the 16-bit modes give twice as many sample slots as the 24-bit and 32-bit modes. A serializer pops samples from the other side. Each popped sample appears one cycle later, right-justified and zero-extended to 32 bits, with a valid strobe. Level, full and empty report occupancy in samples. Sticky flags record a dropped push and a pop made while the FIFO was empty. Changing the mode flushes all stored and staged data.

Top module: `smp_wr_packer`

## Requirements
- R1: The mode input selects the sample length. 2'b00 and 2'b01 give 16 bits (byte lanes 0 to 1). 2'b11 gives 24 bits (lanes 0 to 2). 2'b10 gives 32 bits (lanes 0 to 3).
- R2: The FIFO holds SLOTS/2 samples in the 16-bit modes and SLOTS/4 samples in the 24-bit and 32-bit modes. `full` is high exactly when `level` equals that depth, and `empty` is high exactly when `level` is 0.
- R3: Written bytes in lanes above the selected length are discarded. A popped sample has zeros in every bit above its length.
- R4: A write whose enabled lanes all lie above the selected length causes no push and leaves the staging register unchanged.
- R5: A write with the top lane of the selected length enabled pushes one sample. That sample is built from this write's enabled valid lanes plus any lanes staged by earlier writes. A write without the top lane only stages its valid lanes. The staging register is cleared after each push.
- R6: A push made while `full` is high is dropped, and it sets `overflow`, which stays high until reset.
- R7: A pop made while `empty` is high leaves `rd_valid` low and `rd_data` at zero in the next cycle. It sets `underflow`, which stays high until reset.
- R8: A pop made while the FIFO is not empty drives `rd_valid` high in the next cycle, with `rd_data` carrying the oldest stored sample. Samples leave in the order they were pushed. `rd_data` is zero whenever `rd_valid` is low.
- R9: In the cycle when `mode` differs from its value in the previous cycle, the FIFO and the staging register are cleared, and that cycle's write and pop are ignored.
- R10: After reset, `level` is 0, `empty` is 1, and `full`, `overflow`, `underflow` and `rd_valid` are 0.
- R11: `level` counts samples. A push and a pop in the same cycle, made while the FIFO is neither full nor empty, leave `level` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Sample length and FIFO geometry select |
| wr_en | input | 1 | Bus write strobe |
| wr_be | input | 4 | Byte enables, bit n for bits 8n+7:8n |
| wr_data | input | 32 | Bus write data |
| rd_en | input | 1 | Pop request from the serializer |
| rd_valid | output | 1 | Popped sample present on rd_data |
| rd_data | output | 32 | Popped sample, right-justified, zero-extended |
| level | output | $clog2(SLOTS/2+1) | Stored sample count |
| full | output | 1 | FIFO at the depth of the current mode |
| empty | output | 1 | FIFO holds no sample |
| overflow | output | 1 | Sticky: a push was dropped |
| underflow | output | 1 | Sticky: a pop found the FIFO empty |

## Verification
The hardest case to reach is a sample split across narrow writes with a disruption between the parts. The disruption is a write that hits only unused lanes, or a mode change that must discard what was staged. The stimulus stages low bytes, then sends a write to unused lanes or changes the mode, and then writes only the top lane. Whether the pushed sample has zero low bytes shows whether the staged bytes were kept or discarded. A long mixed phase with rare mode changes also drives push-on-full, pop-on-empty and simultaneous push and pop at both depths. In every cycle the results are compared against a queue-based model.

// File: rtl/smp_pkg.sv
package smp_pkg;
  localparam int LANES = 4;

  typedef enum logic [1:0] {
    MD_S16A = 2'b00,
    MD_S16B = 2'b01,
    MD_S32  = 2'b10,
    MD_S24  = 2'b11
  } smp_mode_e;

  // byte lanes that belong to the selected sample length
  function automatic logic [LANES-1:0] lane_mask(input logic [1:0] m);
    case (m)
      MD_S24:  lane_mask = 4'b0111;
      MD_S32:  lane_mask = 4'b1111;
      default: lane_mask = 4'b0011;
    endcase
  endfunction

  // lane whose write completes a sample
  function automatic logic [1:0] top_lane(input logic [1:0] m);
    case (m)
      MD_S24:  top_lane = 2'd2;
      MD_S32:  top_lane = 2'd3;
      default: top_lane = 2'd1;
    endcase
  endfunction
endpackage

// File: rtl/smp_lane_stage.sv
module smp_lane_stage
  import smp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic [1:0]       mode,
  input  logic             wr_en,
  input  logic [LANES-1:0] wr_be,
  input  logic [8*LANES-1:0] wr_data,
  output logic             push,
  output logic [8*LANES-1:0] push_data
);
  logic [LANES-1:0]   eff_be;
  logic [8*LANES-1:0] stage_q;
  logic [8*LANES-1:0] merged;

  assign eff_be = wr_be & lane_mask(mode);

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign merged[8*b +: 8] = eff_be[b] ? wr_data[8*b +: 8] : stage_q[8*b +: 8];
  end

  assign push = wr_en && !flush && eff_be[top_lane(mode)];
  assign push_data = merged;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      stage_q <= '0;
    end else if (wr_en && (|eff_be)) begin
      stage_q <= push ? '0 : merged;
    end
  end
endmodule

// File: rtl/smp_store.sv
module smp_store #(
  parameter int WORDS = 4,
  parameter int WA_W  = 2,
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic [LANES-1:0]   we,
  input  logic [WA_W-1:0]    waddr,
  input  logic [8*LANES-1:0] wdata,
  input  logic               re,
  input  logic [WA_W-1:0]    raddr,
  output logic [8*LANES-1:0] rword
);
  logic [8*LANES-1:0] mem [WORDS];

  for (genvar b = 0; b < LANES; b++) begin : g_bwe
    always_ff @(posedge clk) begin
      if (we[b]) mem[waddr][8*b +: 8] <= wdata[8*b +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (re) rword <= mem[raddr];
  end
endmodule

// File: rtl/smp_ptr_ctrl.sv
module smp_ptr_ctrl #(
  parameter int SLOTS = 16,
  parameter int PTR_W = 3,
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic [1:0]       mode,
  input  logic             push,
  input  logic             rd_en,
  output logic             push_ok,
  output logic             pop_ok,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty,
  output logic             overflow,
  output logic             underflow
);
  localparam int D16 = SLOTS / 2;
  localparam int D32 = SLOTS / 4;

  logic [LVL_W-1:0] depth;
  logic [LVL_W-1:0] level_n;

  assign depth   = mode[1] ? LVL_W'(D32) : LVL_W'(D16);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = rd_en && !empty && !flush;
  assign level_n = level + LVL_W'(push_ok) - LVL_W'(pop_ok);

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p,
                                            input logic [LVL_W-1:0] d);
    bump = (LVL_W'(p) == d - 1'b1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      full   <= 1'b0;
      empty  <= 1'b1;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr, depth);
      if (pop_ok)  rd_ptr <= bump(rd_ptr, depth);
      level <= level_n;
      full  <= (level_n == depth);
      empty <= (level_n == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else if (!flush) begin
      if (push && full)   overflow  <= 1'b1;
      if (rd_en && empty) underflow <= 1'b1;
    end
  end
endmodule

// File: rtl/smp_wr_packer.sv
module smp_wr_packer
  import smp_pkg::*;
#(
  parameter int SLOTS = 16,
  localparam int D16   = SLOTS / 2,
  localparam int WORDS = SLOTS / 4,
  localparam int PTR_W = $clog2(D16),
  localparam int WA_W  = $clog2(WORDS),
  localparam int LVL_W = $clog2(D16 + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic             wr_en,
  input  logic [3:0]       wr_be,
  input  logic [31:0]      wr_data,
  input  logic             rd_en,
  output logic             rd_valid,
  output logic [31:0]      rd_data,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty,
  output logic             overflow,
  output logic             underflow
);
  logic [1:0]       mode_q;
  logic             flush;
  logic             push, push_ok, pop_ok;
  logic [31:0]      push_data;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [3:0]       mem_we;
  logic [31:0]      mem_wdata, rword;
  logic [WA_W-1:0]  waddr, raddr;
  logic             rd_ok_q, rd_half_q, rd_m16_q;
  logic             m16;

  always_ff @(posedge clk) mode_q <= mode;

  assign flush = !rst && (mode != mode_q);
  assign m16   = !mode_q[1];

  smp_lane_stage u_stage (
    .clk(clk), .rst(rst), .flush(flush), .mode(mode_q),
    .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .push(push), .push_data(push_data)
  );

  smp_ptr_ctrl #(.SLOTS(SLOTS), .PTR_W(PTR_W), .LVL_W(LVL_W)) u_ctrl (
    .clk(clk), .rst(rst), .flush(flush), .mode(mode),
    .push(push), .rd_en(rd_en), .push_ok(push_ok), .pop_ok(pop_ok),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .level(level), .full(full),
    .empty(empty), .overflow(overflow), .underflow(underflow)
  );

  // 16-bit samples share a word two to a slot; wider samples take a whole word
  always_comb begin
    if (m16) begin
      waddr     = wr_ptr[PTR_W-1:1];
      raddr     = rd_ptr[PTR_W-1:1];
      mem_we    = !push_ok ? 4'b0000 : (wr_ptr[0] ? 4'b1100 : 4'b0011);
      mem_wdata = {push_data[15:0], push_data[15:0]};
    end else begin
      waddr     = wr_ptr[WA_W-1:0];
      raddr     = rd_ptr[WA_W-1:0];
      mem_we    = {4{push_ok}};
      mem_wdata = push_data;
    end
  end

  smp_store #(.WORDS(WORDS), .WA_W(WA_W), .LANES(LANES)) u_store (
    .clk(clk), .we(mem_we), .waddr(waddr), .wdata(mem_wdata),
    .re(pop_ok), .raddr(raddr), .rword(rword)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ok_q   <= 1'b0;
      rd_half_q <= 1'b0;
      rd_m16_q  <= 1'b1;
    end else begin
      rd_ok_q   <= pop_ok;
      rd_half_q <= rd_ptr[0];
      rd_m16_q  <= m16;
    end
  end

  assign rd_valid = rd_ok_q;
  always_comb begin
    if (!rd_ok_q)     rd_data = '0;
    else if (rd_m16_q) rd_data = {16'h0, rd_half_q ? rword[31:16] : rword[15:0]};
    else               rd_data = rword;
  end
endmodule

// File: rtl/smp_wr_packer_chk.sv
module smp_wr_packer_chk #(
  parameter int SLOTS = 16,
  parameter int LVL_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode,
  input logic             rd_en,
  input logic             rd_valid,
  input logic [31:0]      rd_data,
  input logic [LVL_W-1:0] level,
  input logic             full,
  input logic             empty,
  input logic             overflow,
  input logic             underflow
);
  localparam int D16 = SLOTS / 2;
  localparam int D32 = SLOTS / 4;

  p_flags_excl_r2: assert property (@(posedge clk) disable iff (rst) !(full && empty));
  p_level_max_r2: assert property (@(posedge clk) disable iff (rst) level <= LVL_W'(D16));
  p_level_wide_r2: assert property (@(posedge clk) disable iff (rst)
    (mode[1] && mode == $past(mode)) |-> level <= LVL_W'(D32));
  p_no_overflow_clear_r6: assert property (@(posedge clk) disable iff (rst) overflow |=> overflow);
  p_no_underflow_clear_r7: assert property (@(posedge clk) disable iff (rst) underflow |=> underflow);
  p_valid_after_pop_r8: assert property (@(posedge clk) disable iff (rst) rd_valid |-> $past(rd_en));
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst) !rd_valid |-> rd_data == 32'h0);
  p_flush_level_r9: assert property (@(posedge clk) disable iff (rst)
    (mode != $past(mode)) |=> level == '0);
  p_zext24_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && mode == 2'b11 && $past(mode) == 2'b11) |-> rd_data[31:24] == 8'h0);
  p_zext16_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !mode[1] && !$past(mode[1])) |-> rd_data[31:16] == 16'h0);
endmodule

bind smp_wr_packer smp_wr_packer_chk #(.SLOTS(SLOTS), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .rd_en(rd_en), .rd_valid(rd_valid),
  .rd_data(rd_data), .level(level), .full(full), .empty(empty),
  .overflow(overflow), .underflow(underflow)
);

// File: tb/smp_wr_packer_bench.sv
`timescale 1ns/1ps
module smp_wr_packer_bench;
  localparam int SLOTS = 16;
  localparam int D16 = SLOTS / 2;
  localparam int D32 = SLOTS / 4;
  localparam int LVL_W = $clog2(D16 + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode = 2'b00;
  logic wr_en = 1'b0;
  logic [3:0] wr_be = 4'h0;
  logic [31:0] wr_data = 32'h0;
  logic rd_en = 1'b0;
  logic rd_valid;
  logic [31:0] rd_data;
  logic [LVL_W-1:0] level;
  logic full, empty, overflow, underflow;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  smp_wr_packer #(.SLOTS(SLOTS)) u_smp_wr_packer (
    .clk(clk), .rst(rst), .mode(mode), .wr_en(wr_en), .wr_be(wr_be),
    .wr_data(wr_data), .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data),
    .level(level), .full(full), .empty(empty), .overflow(overflow),
    .underflow(underflow)
  );

  // behavioural reference
  logic [31:0] q[$];
  logic [31:0] m_stage;
  logic [1:0]  m_mode_q;
  logic [31:0] m_rd_data;
  bit m_rd_valid, m_ovf, m_unf;

  function automatic int nbytes(input logic [1:0] m);
    return (m == 2'b11) ? 3 : (m == 2'b10) ? 4 : 2;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      q.delete(); m_stage = 0; m_mode_q = mode;
      m_rd_valid = 0; m_rd_data = 0; m_ovf = 0; m_unf = 0;
    end else if (mode != m_mode_q) begin
      q.delete(); m_stage = 0; m_mode_q = mode;
      m_rd_valid = 0; m_rd_data = 0;
    end else begin
      int dep, nb;
      bit was_full, was_empty, any;
      logic [31:0] mrg;
      dep = mode[1] ? D32 : D16;
      nb = nbytes(mode);
      was_full = (q.size() == dep);
      was_empty = (q.size() == 0);
      m_rd_valid = 0; m_rd_data = 0;
      if (rd_en) begin
        if (was_empty) m_unf = 1;
        else begin m_rd_valid = 1; m_rd_data = q.pop_front(); end
      end
      if (wr_en) begin
        mrg = m_stage; any = 0;
        for (int b = 0; b < nb; b++)
          if (wr_be[b]) begin mrg[8*b +: 8] = wr_data[8*b +: 8]; any = 1; end
        if (wr_be[nb-1]) begin
          if (was_full) m_ovf = 1; else q.push_back(mrg);
          m_stage = 0;
        end else if (any) m_stage = mrg;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_model();
    int dep;
    dep = m_mode_q[1] ? D32 : D16;
    chk("R8 rd_valid", 32'(rd_valid), 32'(m_rd_valid));
    chk("R8 rd_data", rd_data, m_rd_data);
    chk("R11 level", 32'(level), 32'(q.size()));
    chk("R2 full", 32'(full), 32'(q.size() == dep));
    chk("R2 empty", 32'(empty), 32'(q.size() == 0));
    chk("R6 overflow", 32'(overflow), 32'(m_ovf));
    chk("R7 underflow", 32'(underflow), 32'(m_unf));
  endtask

  // drive at negedge, let one posedge pass, compare at the next negedge
  task automatic step(input bit we, input logic [3:0] be, input logic [31:0] d, input bit re);
    wr_en = we; wr_be = be; wr_data = d; rd_en = re;
    @(posedge clk);
    @(negedge clk);
    compare_model();
  endtask

  task automatic wr(input logic [3:0] be, input logic [31:0] d);
    step(1, be, d, 0);
  endtask

  task automatic pop();
    step(0, 4'h0, 32'h0, 1);
  endtask

  task automatic idle();
    step(0, 4'h0, 32'h0, 0);
  endtask

  initial begin : watchdog
    while (!done && cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst = 1'b1;
    repeat (3) idle();
    rst = 1'b0;
    idle();
    // R10 reset state
    chk("R10 level", 32'(level), 0);
    chk("R10 empty", 32'(empty), 1);
    chk("R10 full", 32'(full), 0);
    chk("R10 flags", {30'h0, overflow, underflow}, 0);
    chk("R10 rd_valid", 32'(rd_valid), 0);

    // 16-bit mode
    wr(4'b1111, 32'hAABB1234);
    chk("R5 one-write push", 32'(level), 1);
    wr(4'b0001, 32'h000000CD);
    chk("R5 low byte stages only", 32'(level), 1);
    wr(4'b0010, 32'h0000EF00);
    wr(4'b1100, 32'hFFFF0000);
    chk("R4 unused lanes no push", 32'(level), 2);
    wr(4'b0010, 32'h00001100);
    pop();
    chk("R3 16-bit upper bytes dropped", rd_data, 32'h00001234);
    pop();
    chk("R5 two-write merge", rd_data, 32'h0000EFCD);
    pop();
    chk("R4 staging untouched", rd_data, 32'h00001100);
    pop();
    chk("R7 empty pop valid", 32'(rd_valid), 0);
    chk("R7 underflow", 32'(underflow), 1);
    for (int i = 0; i < D16; i++) wr(4'b0011, 32'(i + 16'h0100));
    chk("R2 full at 16-bit depth", {31'h0, full}, 1);
    wr(4'b0011, 32'h0000DEAD);
    chk("R6 overflow", 32'(overflow), 1);
    chk("R6 level kept", 32'(level), D16);
    pop();
    chk("R8 order", rd_data, 32'h00000100);
    step(1, 4'b0011, 32'h00004444, 1);
    chk("R11 push+pop level", 32'(level), D16 - 1);
    chk("R8 order 2", rd_data, 32'h00000101);

    // 24-bit mode, the change cycle carries a write that must be ignored
    mode = 2'b11;
    wr(4'b1111, 32'h11111111);
    chk("R9 flush level", 32'(level), 0);
    wr(4'b0001, 32'h00000056);
    wr(4'b0010, 32'h00003400);
    wr(4'b0100, 32'h00120000);
    chk("R1 24-bit push on lane 2", 32'(level), 1);
    wr(4'b1000, 32'h99000000);
    chk("R4 top byte only", 32'(level), 1);
    wr(4'b1111, 32'hFF654321);
    pop();
    chk("R1 24-bit sample", rd_data, 32'h00123456);
    pop();
    chk("R3 24-bit top byte zero", rd_data, 32'h00654321);
    for (int i = 0; i < D32; i++) wr(4'b0111, 32'(i));
    chk("R2 full at 24-bit depth", {31'h0, full}, 1);

    // 32-bit mode, staged byte then a mode change
    mode = 2'b10;
    idle();
    wr(4'b0001, 32'h00000077);
    mode = 2'b01;
    idle();
    wr(4'b0010, 32'h00005500);
    pop();
    chk("R9 staging cleared", rd_data, 32'h00005500);
    mode = 2'b10;
    idle();
    wr(4'b0001, 32'h000000EF);
    wr(4'b0010, 32'h0000BE00);
    wr(4'b0100, 32'h00AD0000);
    chk("R1 32-bit lane 2 no push", 32'(level), 0);
    wr(4'b1000, 32'hDE000000);
    pop();
    chk("R1 32-bit sample", rd_data, 32'hDEADBEEF);

    // mixed traffic
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 99) == 0) mode = 2'($urandom);
      step(1'($urandom_range(0, 1)), 4'($urandom), $urandom, $urandom_range(0, 2) == 0);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule